// File: doc/BRIEF.md
# Tuner Reference Divider with Phase-Frequency Detector

This block sits in the synthesizer loop of a broadcast tuner. It divides the crystal reference clock by one of three ratios, picked by two ratio-select bits, and emits a one-cycle comparison pulse at each terminal count. The pulse is the phase-comparison clock.

A three-state phase-frequency detector compares that pulse with rising edges of the feedback clock from the programmable loop divider. The feedback clock is synchronised into the reference domain first. The detector drives pump-up and pump-down commands for an external charge pump.

Three control bits are handled here:
- pump-off forces both pump commands inactive;
- pump-current selects the high or low pump current;
- tuning-off disables the varicap drive.

A lock monitor watches the pump pulse widths over successive comparison periods. With a 4 MHz crystal, the three ratios give oscillator steps of 31.25, 50 and 62.5 kHz, because the step is twice the comparison frequency.

Top module: `refdiv_pfd`

## Requirements
- R1: With ratio bits (hi, lo) = (0, 1), comparison pulses recur every 256 reference cycles.
- R2: With ratio bits (hi, lo) = (1, 1), comparison pulses recur every 128 reference cycles.
- R3: With lo = 0, comparison pulses recur every 160 reference cycles, whatever the value of hi.
- R4: A change of ratio bits leaves the comparison period in progress at its old length. The period after the next pulse uses the new ratio.
- R5: When the feedback rising edge is driven N cycles after the comparison pulse is seen, pump-up is high for N+2 cycles.
- R6: When the feedback edge leads, pump-down is high. With the feedback edge driven M cycles after one comparison pulse in a period of P, pump-down lasts P-M-2 cycles and is cleared by the next pulse. Pump-up and pump-down are never high together.
- R7: While pump-off is 1, pump-up and pump-down are both 0. The detector keeps running internally, so a pending command reappears when pump-off returns to 0.
- R8: The pump-current output equals the pump-current control bit (1 = high current, 0 = low).
- R9: The tuning-disable output equals the tuning-off control bit (1 = varicap drive off).
- R10: Lock is set after 16 consecutive comparison periods in which every pump pulse lasts fewer than 4 cycles. A period with a pulse of 4 cycles or more clears lock at the next comparison pulse. Lock changes only in the cycle after a comparison pulse.
- R11: Directly after reset, pump-up, pump-down and lock are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_clk | input | 1 | Feedback clock from the loop divider (asynchronous) |
| rsel_hi | input | 1 | Ratio-select high bit |
| rsel_lo | input | 1 | Ratio-select low bit |
| pump_hi | input | 1 | Pump current select control (1 = high) |
| pump_off | input | 1 | Pump disable control |
| vt_off_req | input | 1 | Tuning-output disable control |
| cmp_pulse | output | 1 | Comparison pulse, one cycle per period |
| pump_up | output | 1 | Charge-pump up command |
| pump_dn | output | 1 | Charge-pump down command |
| pump_isel | output | 1 | Charge-pump current select |
| vt_disable | output | 1 | Varicap drive disable |
| pll_locked | output | 1 | Lock indicator |

## Verification
The assertions hold on every cycle for these properties:
- the pump commands are mutually exclusive;
- they stay silent while pump-off is set;
- a rising pump-up follows a comparison pulse or a release of pump-off;
- the comparison pulse is one cycle wide;
- lock moves only right after a comparison pulse.

Other behaviour shows only in the bench's scenarios. This covers the exact period for each ratio code and the deferred ratio switch. It also covers the pump-pulse widths for leading and lagging feedback and the 16-period lock count, including its loss and recovery.

// File: rtl/refdiv_pfd_pkg.sv
package refdiv_pfd_pkg;

   // Ratio selection decoded from the two select bits.
   typedef enum logic [1:0] {
      RSEL_MID = 2'b00,   // lo = 0, hi ignored
      RSEL_TOP = 2'b01,   // hi = 0, lo = 1
      RSEL_LOW = 2'b11    // hi = 1, lo = 1
   } rsel_e;

   function automatic rsel_e decode_rsel(input logic hi, input logic lo);
      if (!lo)
         return RSEL_MID;
      else if (hi)
         return RSEL_LOW;
      else
         return RSEL_TOP;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/refdiv_pfd_refdiv.sv
module refdiv_pfd_refdiv
   import refdiv_pfd_pkg::*;
#(
   parameter int DIV_TOP = 256,
   parameter int DIV_LOW = 128,
   parameter int DIV_MID = 160
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rsel_hi,
   input  logic rsel_lo,
   output logic tick
);
   localparam int MAXR  = max3(DIV_TOP, DIV_LOW, DIV_MID);
   localparam int CNT_W = $clog2(MAXR);
   localparam logic [CNT_W-1:0] LD_TOP = CNT_W'(DIV_TOP - 1);
   localparam logic [CNT_W-1:0] LD_LOW = CNT_W'(DIV_LOW - 1);
   localparam logic [CNT_W-1:0] LD_MID = CNT_W'(DIV_MID - 1);

   if (DIV_TOP < 2 || DIV_LOW < 2 || DIV_MID < 2) begin : g_bad_ratio
      $error("refdiv_pfd_refdiv: every ratio must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;
   rsel_e            sel;

   // Ratio bits are sampled only when the count reloads, so a change
   // never shortens the period in progress.
   always_comb begin
      sel = decode_rsel(rsel_hi, rsel_lo);
      unique case (sel)
         RSEL_TOP: reload = LD_TOP;
         RSEL_LOW: reload = LD_LOW;
         default:  reload = LD_MID;
      endcase
   end

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= reload;
      else
         cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/refdiv_pfd_fbsync.sv
module refdiv_pfd_fbsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fb_async,
   output logic fb_rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("refdiv_pfd_fbsync: at least two stages are required");
   end

   logic [STAGES-1:0] sq;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq[i] <= 1'b0;
            else        sq[i] <= fb_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq[i] <= 1'b0;
            else        sq[i] <= sq[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sq[STAGES-1];
   end

   assign fb_rise = sq[STAGES-1] & ~last_q;
endmodule

// File: rtl/refdiv_pfd_detector.sv
module refdiv_pfd_detector (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_evt,
   input  logic fb_evt,
   output logic up_q,
   output logic dn_q
);
   logic up_n, dn_n;

   always_comb begin
      up_n = up_q | ref_evt;
      dn_n = dn_q | fb_evt;
      if (up_n && dn_n) begin
         up_n = 1'b0;
         dn_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_n;
         dn_q <= dn_n;
      end
   end
endmodule

// File: rtl/refdiv_pfd_lockmon.sv
module refdiv_pfd_lockmon #(
   parameter int WIDTH_TOL = 4,
   parameter int GOOD_RUNS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pulse_act,
   output logic locked
);
   localparam int W_W = $clog2(WIDTH_TOL + 1);
   localparam int G_W = $clog2(GOOD_RUNS + 1);
   localparam logic [W_W-1:0] W_SAT = W_W'(WIDTH_TOL);
   localparam logic [G_W-1:0] G_SAT = G_W'(GOOD_RUNS);

   if (WIDTH_TOL < 1 || GOOD_RUNS < 1) begin : g_bad_lock
      $error("refdiv_pfd_lockmon: tolerance and run count must be positive");
   end

   logic [W_W-1:0] wid_q;
   logic [G_W-1:0] good_q;
   logic           bad_q;
   logic           over;
   logic           period_bad;

   assign over       = (wid_q == W_SAT);
   assign period_bad = bad_q | over;

   // Width of the current pump pulse, saturating at the tolerance.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wid_q <= '0;
      else if (!pulse_act)
         wid_q <= '0;
      else if (!over)
         wid_q <= wid_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bad_q <= 1'b0;
      else if (tick)
         bad_q <= 1'b0;
      else
         bad_q <= period_bad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         good_q <= '0;
      else if (tick) begin
         if (period_bad)
            good_q <= '0;
         else if (good_q != G_SAT)
            good_q <= good_q + 1'b1;
      end
   end

   assign locked = (good_q == G_SAT);
endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd #(
   parameter int DIV_TOP     = 256,
   parameter int DIV_LOW     = 128,
   parameter int DIV_MID     = 160,
   parameter int SYNC_STAGES = 2,
   parameter int WIDTH_TOL   = 4,
   parameter int GOOD_RUNS   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fb_clk,
   input  logic rsel_hi,
   input  logic rsel_lo,
   input  logic pump_hi,
   input  logic pump_off,
   input  logic vt_off_req,
   output logic cmp_pulse,
   output logic pump_up,
   output logic pump_dn,
   output logic pump_isel,
   output logic vt_disable,
   output logic pll_locked
);
   logic tick;
   logic fb_rise;
   logic up_q, dn_q;

   refdiv_pfd_refdiv #(
      .DIV_TOP(DIV_TOP), .DIV_LOW(DIV_LOW), .DIV_MID(DIV_MID)
   ) u_div (
      .clk(clk), .rst_n(rst_n),
      .rsel_hi(rsel_hi), .rsel_lo(rsel_lo),
      .tick(tick)
   );

   refdiv_pfd_fbsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .fb_async(fb_clk), .fb_rise(fb_rise)
   );

   refdiv_pfd_detector u_det (
      .clk(clk), .rst_n(rst_n),
      .ref_evt(tick), .fb_evt(fb_rise),
      .up_q(up_q), .dn_q(dn_q)
   );

   refdiv_pfd_lockmon #(
      .WIDTH_TOL(WIDTH_TOL), .GOOD_RUNS(GOOD_RUNS)
   ) u_lock (
      .clk(clk), .rst_n(rst_n),
      .tick(tick), .pulse_act(up_q | dn_q),
      .locked(pll_locked)
   );

   assign cmp_pulse  = tick;
   assign pump_up    = up_q & ~pump_off;
   assign pump_dn    = dn_q & ~pump_off;
   assign pump_isel  = pump_hi;
   assign vt_disable = vt_off_req;
endmodule

// File: rtl/refdiv_pfd_chk.sv
module refdiv_pfd_chk (
   input logic clk,
   input logic rst_n,
   input logic pump_off,
   input logic cmp_pulse,
   input logic pump_up,
   input logic pump_dn,
   input logic pll_locked
);
   a_r7_off_silences_pump: assert property (@(posedge clk) disable iff (!rst_n)
      pump_off |-> (!pump_up && !pump_dn));

   a_r6_up_dn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pump_up, pump_dn}));

   a_r5_up_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pump_up) |-> ($past(cmp_pulse) || $past(pump_off)));

   a_r1_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_pulse |=> !cmp_pulse);

   a_r10_lock_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_locked) |-> $past(cmp_pulse));

   a_r10_lock_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_locked) |-> $past(cmp_pulse));
endmodule

bind refdiv_pfd refdiv_pfd_chk chk_i (
   .clk(clk), .rst_n(rst_n), .pump_off(pump_off),
   .cmp_pulse(cmp_pulse), .pump_up(pump_up), .pump_dn(pump_dn),
   .pll_locked(pll_locked)
);

// File: tb/refdiv_pfd_tb_top.sv
`timescale 1ns/1ps
module refdiv_pfd_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fb_clk = 1'b0;
   logic rsel_hi = 1'b0, rsel_lo = 1'b0;
   logic pump_hi = 1'b0, pump_off = 1'b0, vt_off_req = 1'b0;
   logic cmp_pulse, pump_up, pump_dn, pump_isel, vt_disable, pll_locked;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int up_run = 0, dn_run = 0;
   int last_up = -1, last_dn = -1;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   refdiv_pfd dut_i (
      .clk(clk), .rst_n(rst_n), .fb_clk(fb_clk),
      .rsel_hi(rsel_hi), .rsel_lo(rsel_lo),
      .pump_hi(pump_hi), .pump_off(pump_off), .vt_off_req(vt_off_req),
      .cmp_pulse(cmp_pulse), .pump_up(pump_up), .pump_dn(pump_dn),
      .pump_isel(pump_isel), .vt_disable(vt_disable), .pll_locked(pll_locked)
   );

   // Pulse-width monitor on the pump outputs.
   always @(negedge clk) begin
      if (pump_up) up_run++;
      else if (up_run > 0) begin last_up = up_run; up_run = 0; end
      if (pump_dn) dn_run++;
      else if (dn_run > 0) begin last_dn = dn_run; dn_run = 0; end
   end

   function automatic int exp_ratio(input logic hi, input logic lo);
      if (!lo) return 160;
      return hi ? 128 : 256;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic wait_pulse();
      do @(negedge clk); while (!cmp_pulse);
   endtask

   task automatic measure(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!cmp_pulse);
   endtask

   task automatic fb_strobe();
      fb_clk = 1'b1;
      @(negedge clk);
      fb_clk = 1'b0;
   endtask

   // Feedback edge driven N cycles after the observed pulse.
   task automatic lag_period(input int n);
      wait_pulse();
      repeat (n) @(negedge clk);
      fb_strobe();
   endtask

   initial begin
      int n, p, w, m;
      logic h, l;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: state directly after reset release, before any active edge
      check(pump_up == 0, "R11 up", pump_up, 0);
      check(pump_dn == 0, "R11 dn", pump_dn, 0);
      check(pll_locked == 0, "R11 lock", pll_locked, 0);

      // R1, R2, R3: directed codes then random codes
      for (int k = 0; k < 10; k++) begin
         if (k < 4) begin h = k[1]; l = k[0]; end
         else begin h = $urandom_range(0, 1); l = $urandom_range(0, 1); end
         rsel_hi = h; rsel_lo = l;
         wait_pulse();
         measure(n);   // may still be old ratio
         measure(n);
         p = exp_ratio(h, l);
         if (!l)     check(n == p, "R3 mid ratio period", n, p);
         else if (h) check(n == p, "R2 low ratio period", n, p);
         else        check(n == p, "R1 top ratio period", n, p);
      end

      // R4: change ratio mid period
      rsel_hi = 1'b0; rsel_lo = 1'b1;
      wait_pulse();
      repeat (5) @(negedge clk);
      rsel_hi = 1'b1; rsel_lo = 1'b1;
      measure(n);
      check(n == 256 - 5, "R4 old period kept", n, 251);
      measure(n);
      check(n == 128, "R4 new ratio next", n, 128);

      // R5: lagging feedback, ratio 128
      for (int k = 0; k < 8; k++) lag_period(0);
      for (int k = 0; k < 10; k++) begin
         n = (k == 0) ? 0 : (k == 1) ? 20 : $urandom_range(0, 20);
         lag_period(n);
         repeat (n + 6) @(negedge clk);
         check(last_up == n + 2, "R5 up width", last_up, n + 2);
      end

      // R6: leading feedback gives pump-down
      for (int k = 0; k < 8; k++) begin
         w = (k == 0) ? 1 : $urandom_range(1, 20);
         m = 128 - 2 - w;
         wait_pulse();
         fb_strobe();                 // align, clears pending up
         repeat (m - 1) @(negedge clk);
         fb_strobe();
         wait_pulse();
         repeat (3) @(negedge clk);
         check(last_dn == w, "R6 dn width", last_dn, w);
      end

      // R10: lock acquisition, loss and recovery
      for (int k = 0; k < 24; k++) lag_period(0);
      repeat (3) @(negedge clk);
      check(pll_locked == 1, "R10 lock after good run", pll_locked, 1);
      lag_period(10);
      wait_pulse();
      repeat (2) @(negedge clk);
      check(pll_locked == 0, "R10 lock lost on wide pulse", pll_locked, 0);
      for (int k = 0; k < 8; k++) lag_period(0);
      repeat (3) @(negedge clk);
      check(pll_locked == 0, "R10 no lock after 8 periods", pll_locked, 0);
      for (int k = 0; k < 20; k++) lag_period(0);
      repeat (3) @(negedge clk);
      check(pll_locked == 1, "R10 lock regained", pll_locked, 1);

      // R7: pump-off silences commands, internal state survives
      pump_off = 1'b1;
      lag_period(8);
      n = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (pump_up || pump_dn) n++;
      end
      check(n == 0, "R7 pump silent while off", n, 0);
      pump_off = 1'b0;   // no feedback since: up pending internally
      #1;
      check(pump_up == 1, "R7 pending up reappears", pump_up, 1);

      // R8, R9: control pass-through
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         pump_hi = $urandom_range(0, 1);
         vt_off_req = $urandom_range(0, 1);
         #1;
         check(pump_isel == pump_hi, "R8 current select", pump_isel, pump_hi);
         check(vt_disable == vt_off_req, "R9 tuning disable", vt_disable, vt_off_req);
      end

      finish_run();
   end
endmodule